// File: doc/BRIEF.md
# Pipelined Byte-Lane Synchronous SRAM

This block is a single-clock synchronous memory with a registered read pipeline. Address, chip selects, write controls and write data are all captured on the rising clock edge. Read results pass through an output register, and the block reports a drive enable for a shared bidirectional data bus; the pad driver itself sits outside the block. Each word is `LANES` lanes of `LANE_W` bits. Lane i covers data bits `9*i+8 : 9*i` with the default 9-bit lanes, so lane 0 is bits 8:0, lane 1 is 17:9, lane 2 is 26:18 and lane 3 is 35:27.

Each access opens with one of two load strobes. The read-first strobe `lds_rd_n` always starts a read on its own edge, whatever the write controls show. The general strobe `lds_any_n` starts either a read or a write on its own edge, depending on the write controls. Writes use two enable levels. The word-write control `wall_n` writes every lane. Below it, `wsel_n` qualifies the per-lane enables `lane_n`. After a read-first load, a later edge with no strobe and active write controls writes the held address. Storage is a flat register array whose depth is set by a parameter.

Top module: `pipe_sram_bw`

## Requirements
- R1: While reset is held low, and after it is released until a read completes, `dout_en` is 0.
- R2: The block is selected only when `sel0_n`=0, `sel1`=1 and `sel2_n`=0. A strobe edge with any other combination is a deselect. It performs no write. It ends the held access, so later strobe-free edges write nothing. `dout_en` is 0 after the second edge following the deselect.
- R3: A read loaded on edge N puts the addressed word on `dout` after edge N+1. `dout_en` is then 1 while `oe_n` is 0 and no write controls are presented.
- R4: With `wall_n`=0, every lane is written, whatever the values of `wsel_n` and `lane_n`.
- R5: With `wall_n`=1 and `wsel_n`=0, only lanes whose `lane_n` bit is 0 are written. Lane i covers bits `9*i+8 : 9*i`. With all `lane_n` bits at 1, the cycle is a read.
- R6: With `wall_n`=1 and `wsel_n`=1, the cycle is a read, whatever the value of `lane_n`.
- R7: An edge with `lds_rd_n`=0 while selected is a read, even if write controls are active. A later edge with both strobes high and active write controls writes `din` to the held address, and the chip selects are not looked at on that edge.
- R8: `dout_en` follows `oe_n` without waiting for a clock. It is 0 whenever the inputs present a write: `wall_n`=0, or `wsel_n`=0 with any `lane_n` bit at 0.
- R9: After a write edge, `dout_en` stays 0 until a new read has been loaded and completed.
- R10: An edge with no strobe and no write leaves `dout` and the output-valid state unchanged.
- R11: An edge with `lds_any_n`=0 (and `lds_rd_n`=1) while selected, with active write controls, writes `din` at `addr` on that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset of control state |
| addr | input | ADDR_W | Word address, taken on strobe edges |
| sel0_n | input | 1 | Chip select, active low |
| sel1 | input | 1 | Chip select, active high |
| sel2_n | input | 1 | Chip select, active low |
| lds_rd_n | input | 1 | Read-first load strobe, active low |
| lds_any_n | input | 1 | General load strobe, active low |
| wall_n | input | 1 | Whole-word write, active low |
| wsel_n | input | 1 | Lane-write qualifier, active low |
| lane_n | input | LANES | Per-lane write enables, active low |
| oe_n | input | 1 | Output enable, active low, asynchronous |
| din | input | LANES*LANE_W | Write data |
| dout | output | LANES*LANE_W | Registered read data |
| dout_en | output | 1 | Bus drive enable |

## Verification
The hardest case to reach is the two-edge write that opens with a read-first load. On that first edge the read completes from the old contents. On the next edge, which has no strobe, the write controls are active, so the bus must stay undriven while the output register still shows the old word. The stimulus issues the read-first load with the whole-word control low, and the scoreboard expects the old word with the drive enable low. A strobe-free edge with lane enables then follows, and a later read checks that only those lanes changed at the held address. The stimulus also repeats strobe-free writes after a deselect, to show that the held access was dropped.

// File: rtl/pipe_sram_pkg.sv
package pipe_sram_pkg;

  // event carried from the load stage into the output stage
  typedef enum logic [1:0] {
    EV_NONE  = 2'd0,
    EV_READ  = 2'd1,
    EV_CLEAR = 2'd2
  } pipe_ev_e;

  // the three selects agree on "enabled"
  function automatic logic chip_on(input logic a_n, input logic b, input logic c_n);
    return !a_n && b && !c_n;
  endfunction

endpackage

// File: rtl/pipe_sram_ctrl.sv
module pipe_sram_ctrl
  import pipe_sram_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              sel0_n,
  input  logic              sel1,
  input  logic              sel2_n,
  input  logic              lds_rd_n,
  input  logic              lds_any_n,
  input  logic              wall_n,
  input  logic              wsel_n,
  input  logic [LANES-1:0]  lane_n,
  output logic [ADDR_W-1:0] acc_addr,
  output logic [LANES-1:0]  wr_mask,
  output logic              wr_in,
  output logic              rd_go,
  output logic              rd_first,
  output logic              desel,
  output logic              idle
);

  // lanes requested by the write controls on this edge
  function automatic logic [LANES-1:0] lane_req(input logic w_all_n, input logic w_sel_n,
                                                input logic [LANES-1:0] l_n);
    if (!w_all_n)      return '1;
    else if (!w_sel_n) return ~l_n;
    else               return '0;
  endfunction

  logic [LANES-1:0]  lanes_in;
  logic              sel, strobe, start, cont;
  logic              hold_vld;
  logic [ADDR_W-1:0] hold_addr;

  assign lanes_in = lane_req(wall_n, wsel_n, lane_n);
  assign wr_in    = |lanes_in;
  assign sel      = chip_on(sel0_n, sel1, sel2_n);
  assign strobe   = !lds_rd_n || !lds_any_n;
  assign start    = strobe && sel;
  assign desel    = strobe && !sel;
  assign cont     = !strobe && hold_vld;
  assign rd_first = start && !lds_rd_n;

  assign acc_addr = start ? addr : hold_addr;
  assign wr_mask  = ((start && lds_rd_n) || cont) ? lanes_in : '0;
  assign rd_go    = start && (!lds_rd_n || !wr_in);
  assign idle     = !strobe && (wr_mask == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_vld  <= 1'b0;
      hold_addr <= '0;
    end else if (start) begin
      hold_vld  <= 1'b1;
      hold_addr <= addr;
    end else if (desel) begin
      hold_vld  <= 1'b0;
    end
  end

endmodule

// File: rtl/pipe_sram_array.sv
module pipe_sram_array #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic [ADDR_W-1:0]       waddr,
  input  logic [LANES-1:0]        wmask,
  input  logic [LANES*LANE_W-1:0] wdata,
  input  logic [ADDR_W-1:0]       raddr,
  output logic [LANES*LANE_W-1:0] rdata
);

  localparam int DEPTH = 1 << ADDR_W;

  // one independent bank per lane keeps each lane's write in its own process
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] bank [DEPTH];

    always_ff @(posedge clk) begin
      if (wmask[g]) bank[waddr] <= wdata[g*LANE_W +: LANE_W];
    end

    assign rdata[g*LANE_W +: LANE_W] = bank[raddr];
  end

endmodule

// File: rtl/pipe_sram_rdpipe.sv
module pipe_sram_rdpipe
  import pipe_sram_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 36
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_go,
  input  logic              wr_any,
  input  logic              desel,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic              oe_n,
  input  logic              wr_in,
  output logic [ADDR_W-1:0] raddr,
  input  logic [DATA_W-1:0] rdata,
  output logic [DATA_W-1:0] dout,
  output logic              out_vld,
  output logic              dout_en
);

  pipe_ev_e ev_q;

  // load stage: remember what this edge asked for
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ev_q  <= EV_NONE;
      raddr <= '0;
    end else begin
      if (rd_go)                ev_q <= EV_READ;
      else if (wr_any || desel) ev_q <= EV_CLEAR;
      else                      ev_q <= EV_NONE;
      if (rd_go) raddr <= acc_addr;
    end
  end

  // output stage
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dout    <= '0;
      out_vld <= 1'b0;
    end else begin
      unique case (ev_q)
        EV_READ: begin
          dout    <= rdata;
          out_vld <= 1'b1;
        end
        EV_CLEAR: out_vld <= 1'b0;
        default:  ;
      endcase
    end
  end

  assign dout_en = out_vld && !oe_n && !wr_in;

endmodule

// File: rtl/pipe_sram_bw.sv
module pipe_sram_bw #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [ADDR_W-1:0]       addr,
  input  logic                    sel0_n,
  input  logic                    sel1,
  input  logic                    sel2_n,
  input  logic                    lds_rd_n,
  input  logic                    lds_any_n,
  input  logic                    wall_n,
  input  logic                    wsel_n,
  input  logic [LANES-1:0]        lane_n,
  input  logic                    oe_n,
  input  logic [LANES*LANE_W-1:0] din,
  output logic [LANES*LANE_W-1:0] dout,
  output logic                    dout_en
);

  localparam int DATA_W = LANES * LANE_W;

  logic [ADDR_W-1:0] acc_addr_w, raddr_w;
  logic [LANES-1:0]  wr_mask_w;
  logic              wr_in_w, rd_go_w, rd_first_w, desel_w, idle_w, out_vld_w;
  logic [DATA_W-1:0] rdata_w;

  pipe_sram_ctrl #(.ADDR_W(ADDR_W), .LANES(LANES)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .addr(addr),
    .sel0_n(sel0_n), .sel1(sel1), .sel2_n(sel2_n),
    .lds_rd_n(lds_rd_n), .lds_any_n(lds_any_n),
    .wall_n(wall_n), .wsel_n(wsel_n), .lane_n(lane_n),
    .acc_addr(acc_addr_w), .wr_mask(wr_mask_w), .wr_in(wr_in_w),
    .rd_go(rd_go_w), .rd_first(rd_first_w), .desel(desel_w), .idle(idle_w)
  );

  pipe_sram_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_array (
    .clk(clk), .waddr(acc_addr_w), .wmask(wr_mask_w), .wdata(din),
    .raddr(raddr_w), .rdata(rdata_w)
  );

  pipe_sram_rdpipe #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rdpipe (
    .clk(clk), .rst_n(rst_n), .rd_go(rd_go_w), .wr_any(|wr_mask_w),
    .desel(desel_w), .acc_addr(acc_addr_w), .oe_n(oe_n), .wr_in(wr_in_w),
    .raddr(raddr_w), .rdata(rdata_w), .dout(dout), .out_vld(out_vld_w),
    .dout_en(dout_en)
  );

  // R2
  desel_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    desel_w |=> ##1 !out_vld_w);

  // R3
  rd_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_go_w |=> ##1 out_vld_w);

  // R7
  rdfirst_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_first_w |=> ##1 out_vld_w);

  // R9
  wr_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|wr_mask_w) |=> ##1 !out_vld_w);

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    idle_w |=> ##1 ($stable(out_vld_w) && $stable(dout)));

endmodule

// File: tb/tb_pipe_sram_bw.sv
module tb_pipe_sram_bw;

  localparam int AW = 6;
  localparam int DW = 36;
  localparam logic [2:0] SEL = 3'b010;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic          sel0_n = 1'b1, sel1 = 1'b0, sel2_n = 1'b1;
  logic          lds_rd_n = 1'b1, lds_any_n = 1'b1;
  logic          wall_n = 1'b1, wsel_n = 1'b1;
  logic [3:0]    lane_n = 4'hF;
  logic          oe_n = 1'b0;
  logic [DW-1:0] din = '0;
  logic [DW-1:0] dout;
  logic          dout_en;

  int n_vec = 0;
  int n_bad = 0;
  int cyc = 0;

  logic [DW-1:0] ref_mem [64];
  int            q_cyc[$];
  logic [DW-1:0] q_dat[$];
  logic          q_en[$];

  pipe_sram_bw dut (
    .clk(clk), .rst_n(rst_n), .addr(addr),
    .sel0_n(sel0_n), .sel1(sel1), .sel2_n(sel2_n),
    .lds_rd_n(lds_rd_n), .lds_any_n(lds_any_n),
    .wall_n(wall_n), .wsel_n(wsel_n), .lane_n(lane_n),
    .oe_n(oe_n), .din(din), .dout(dout), .dout_en(dout_en)
  );

  always #5 clk = ~clk;

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // lanes a write on this edge would touch, from R4/R5/R6
  function automatic logic [3:0] want_lanes(input logic g_n, input logic b_n, input logic [3:0] e_n);
    if (!g_n) return 4'hF;
    if (!b_n) return ~e_n;
    return 4'h0;
  endfunction

  task automatic model_wr(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic [3:0] m);
    for (int i = 0; i < 4; i++)
      if (m[i]) ref_mem[a][9*i +: 9] = d[9*i +: 9];
  endtask

  // apply one edge's inputs, return at the next falling edge
  task automatic drv(input logic p_n, input logic c_n, input logic [2:0] cs,
                     input logic g_n, input logic b_n, input logic [3:0] e_n,
                     input logic o_n, input logic [AW-1:0] a, input logic [DW-1:0] d);
    lds_rd_n = p_n; lds_any_n = c_n;
    {sel0_n, sel1, sel2_n} = cs;
    wall_n = g_n; wsel_n = b_n; lane_n = e_n;
    oe_n = o_n; addr = a; din = d;
    @(negedge clk);
  endtask

  task automatic idle_cyc(input logic o_n);
    drv(1'b1, 1'b1, SEL, 1'b1, 1'b1, 4'hF, o_n, '0, '0);
  endtask

  // expected result of a read loaded on the coming edge
  task automatic push(input logic [AW-1:0] a, input logic en);
    q_cyc.push_back(cyc + 2);
    q_dat.push_back(ref_mem[a]);
    q_en.push_back(en);
  endtask

  task automatic sb_rd(input logic first, input logic [AW-1:0] a, input logic en);
    push(a, en);
    drv(!first, first, SEL, 1'b1, 1'b1, 4'hF, 1'b0, a, '0);
  endtask

  // R11, R4, R5: write on a general-strobe edge
  task automatic wr_c(input logic [AW-1:0] a, input logic [DW-1:0] d,
                      input logic g_n, input logic b_n, input logic [3:0] e_n);
    model_wr(a, d, want_lanes(g_n, b_n, e_n));
    drv(1'b1, 1'b0, SEL, g_n, b_n, e_n, 1'b1, a, d);
  endtask

  // scoreboard monitor, samples 3 ns after each rising edge
  always @(posedge clk) begin
    cyc = cyc + 1;
    #3;
    if (q_cyc.size() != 0 && q_cyc[0] == cyc) begin
      chk("R3 read data", dout, q_dat[0]);
      chk("R3/R8 drive enable", {35'd0, dout_en}, {35'd0, q_en[0]});
      void'(q_cyc.pop_front());
      void'(q_dat.pop_front());
      void'(q_en.pop_front());
    end
  end

  initial begin
    #1_000_000;
    n_vec++;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) ref_mem[i] = '0;
    repeat (3) @(negedge clk);
    chk("R1 drive off in reset", {35'd0, dout_en}, '0);
    rst_n = 1'b1;
    idle_cyc(1'b0);
    chk("R1 drive off after reset", {35'd0, dout_en}, '0);

    // R4 and R11: whole-word writes with the lane controls scrambled
    for (int i = 0; i < 16; i++) begin
      logic [DW-1:0] pat;
      pat = 36'h9_1234_5678 ^ (36'h0_1F0F_0F13 * DW'(i + 1));
      wr_c(AW'(i), pat, 1'b0, i[0], i[3:0]);
    end
    for (int i = 30; i < 34; i++) wr_c(AW'(i), '0, 1'b0, 1'b1, 4'hF);
    idle_cyc(1'b0);
    // R3: back-to-back reads alternating the two strobes
    for (int i = 0; i < 16; i++) sb_rd(i[0], AW'(i), 1'b1);
    idle_cyc(1'b0);
    idle_cyc(1'b0);

    // R5: masked lane writes
    wr_c(6'd3, 36'hF_EDCB_A987, 1'b1, 1'b0, 4'b1010);
    wr_c(6'd5, 36'h5_5555_5555, 1'b1, 1'b0, 4'b0111);
    wr_c(6'd30, 36'hF_FFFF_FFFF, 1'b1, 1'b0, 4'b1110);
    idle_cyc(1'b0);
    sb_rd(1'b0, 6'd3, 1'b1);
    sb_rd(1'b0, 6'd5, 1'b1);
    drv(1'b1, 1'b0, SEL, 1'b1, 1'b1, 4'hF, 1'b0, 6'd30, '0);
    idle_cyc(1'b0);
    chk("R5 lane 0 is bits 8:0", dout, 36'h0_0000_01FF);

    // R5: lane qualifier low but no lane selected reads
    push(6'd7, 1'b1);
    drv(1'b1, 1'b0, SEL, 1'b1, 1'b0, 4'hF, 1'b0, 6'd7, 36'h0_DEAD_BEEF);
    // R6: both write controls high reads, lanes ignored
    push(6'd9, 1'b1);
    drv(1'b1, 1'b0, SEL, 1'b1, 1'b1, 4'h0, 1'b0, 6'd9, 36'h0_DEAD_BEEF);
    sb_rd(1'b0, 6'd7, 1'b1);
    sb_rd(1'b1, 6'd9, 1'b1);
    idle_cyc(1'b0);
    idle_cyc(1'b0);

    // R7: read-first load with whole-word write low still reads old data,
    // drive is off on the next edge because it presents a write (R8)
    push(6'd12, 1'b0);
    drv(1'b0, 1'b1, SEL, 1'b0, 1'b1, 4'hF, 1'b0, 6'd12, 36'h0_0BAD_0BAD);
    model_wr(6'd12, 36'hA_BCDE_F012, 4'b0011);
    drv(1'b1, 1'b1, 3'b111, 1'b1, 1'b0, 4'b1100, 1'b0, 6'd40, 36'hA_BCDE_F012);
    idle_cyc(1'b0);
    sb_rd(1'b1, 6'd12, 1'b1);
    idle_cyc(1'b0);
    idle_cyc(1'b0);

    // R8: output enable, then R10 hold on strobe-free edges
    drv(1'b1, 1'b0, SEL, 1'b1, 1'b1, 4'hF, 1'b0, 6'd2, '0);
    idle_cyc(1'b1);
    chk("R8 oe_n high blocks drive", {35'd0, dout_en}, '0);
    chk("R3 data under oe_n high", dout, ref_mem[2]);
    oe_n = 1'b0;
    #1;
    chk("R8 drive follows oe_n without clock", {35'd0, dout_en}, 36'd1);
    idle_cyc(1'b0);
    chk("R10 output held", dout, ref_mem[2]);
    chk("R10 drive held", {35'd0, dout_en}, 36'd1);
    wall_n = 1'b0;
    #1;
    chk("R8 write controls block drive", {35'd0, dout_en}, '0);
    wall_n = 1'b1;
    wsel_n = 1'b0; lane_n = 4'b1011;
    #1;
    chk("R8 lane write blocks drive", {35'd0, dout_en}, '0);
    wsel_n = 1'b1; lane_n = 4'hF;
    #1;
    chk("R8 drive returns", {35'd0, dout_en}, 36'd1);

    // R9: bus stays off after a write until a new read completes
    wr_c(6'd20, 36'h1_2345_6789, 1'b0, 1'b1, 4'hF);
    idle_cyc(1'b0);
    chk("R9 off after write", {35'd0, dout_en}, '0);
    idle_cyc(1'b0);
    chk("R9 still off", {35'd0, dout_en}, '0);
    drv(1'b1, 1'b0, SEL, 1'b1, 1'b1, 4'hF, 1'b0, 6'd20, '0);
    idle_cyc(1'b0);
    chk("R9 drive after read", {35'd0, dout_en}, 36'd1);
    chk("R9 written word", dout, 36'h1_2345_6789);

    // R2: deselect turns the bus off by the second edge and writes nothing
    drv(1'b1, 1'b0, SEL, 1'b1, 1'b1, 4'hF, 1'b0, 6'd2, '0);
    drv(1'b1, 1'b0, 3'b110, 1'b1, 1'b1, 4'hF, 1'b0, 6'd2, '0);
    chk("R2 previous read still shown", {35'd0, dout_en}, 36'd1);
    idle_cyc(1'b0);
    chk("R2 off two edges after deselect", {35'd0, dout_en}, '0);
    drv(1'b1, 1'b0, 3'b000, 1'b0, 1'b1, 4'hF, 1'b0, 6'd2, 36'h0_0000_0BAD);
    drv(1'b0, 1'b1, 3'b011, 1'b0, 1'b1, 4'hF, 1'b0, 6'd3, 36'h0_0000_0BAD);
    drv(1'b1, 1'b1, SEL, 1'b0, 1'b1, 4'hF, 1'b0, 6'd4, 36'h0_0000_0BAD);
    drv(1'b1, 1'b1, SEL, 1'b1, 1'b0, 4'h0, 1'b0, 6'd4, 36'h0_0000_0BAD);
    idle_cyc(1'b0);
    sb_rd(1'b0, 6'd2, 1'b1);
    sb_rd(1'b0, 6'd3, 1'b1);
    sb_rd(1'b1, 6'd4, 1'b1);
    sb_rd(1'b0, 6'd12, 1'b1);
    repeat (4) idle_cyc(1'b0);

    chk("R3 scoreboard drained", DW'(q_cyc.size()), '0);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule